// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller

This block sits between a simple host request port and an asynchronous extended-data-out DRAM. Each host request is a read or a write of one 16-bit word at a 20-bit word address, with a 2-bit byte-lane mask. The controller splits the address into a row half and a column half. It places them on a shared 10-bit address bus, and it sequences the row strobe, the two column strobes (one per byte lane), the write strobe and the output enable. All timing minimums and maximums are parameters counted in controller clock cycles.

A row stays open after an access. Later requests that hit the same row are served with column strobes only. A request to a different row, the row-active time limit, or a refresh request closes the row and precharges it. Refresh sequencing lives elsewhere: the controller only closes the row and hands the DRAM over through a request/grant pair. Read data is captured after the column strobe has risen again, because the DRAM holds its output through the column precharge.

Top module: `edo_page_ctrl`

## Requirements
- R1: While reset is high and at the first cycle after it, the row strobe, both column strobes, the write strobe and the output enable are high (inactive), and the data drive enable, the refresh grant and the read-valid pulse are low.
- R2: A new row is opened by driving address bits [19:10] onto the address bus when the row strobe falls. The row strobe then stays low at least T_RCD cycles before any column strobe falls. Address bits [9:0] are on the bus when the column strobe falls, and a column strobe never falls while the row strobe is high.
- R3: Consecutive requests whose address bits [19:10] match the open row are served with column strobes only, and the row strobe stays low between them.
- R4: A request to a different row closes the open row first and then opens the new one, so every row change costs exactly one new row-strobe fall.
- R5: Byte-lane bit 0 selects the lower column strobe and data bits [7:0]. Bit 1 selects the upper column strobe and bits [15:8]. A write changes only the selected bytes in the memory.
- R6: Every write is an early write. The write strobe is already low in the cycle before the column strobe falls, the output enable is high, and the controller drives the data bus. Reads leave the data bus undriven.
- R7: A column strobe stays low at least T_CAS cycles, and it stays high at least T_CP cycles between two falls.
- R8: Read data is sampled while both column strobes are high after the access and no earlier than T_RAC cycles after the row strobe fell. It is returned in request order with a one-cycle valid pulse, and bytes not selected by the lane mask read as zero.
- R9: The row strobe is never low for more than T_RAS_MAX cycles. The controller closes an aged row on its own.
- R10: A refresh request lets a running access finish, closes the row, and raises the grant only while the row and column strobes are high. While the grant is high no host request is accepted. The grant drops once the request is withdrawn, and the next access opens a row again.
- R11: Between two falls, the row strobe stays high at least T_RP cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted at this clock edge when valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, upper half row, lower half column |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane mask, bit 0 lower byte, bit 1 upper byte |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 16 | Read data, unselected bytes zero |
| ref_req | input | 1 | Refresh wants the DRAM |
| ref_gnt | output | 1 | DRAM idle and precharged, handed to refresh |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_casl_n | output | 1 | Lower-byte column strobe, active low |
| dram_cash_n | output | 1 | Upper-byte column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data driven towards the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data returned by the DRAM |

## Verification
The two functions that can collide in one cycle are a same-row hit and the closing of that row, whether by refresh or by row age. The bench raises the refresh request on the same clock edge as a request to the open row. It then checks that the row is closed and granted before the request is taken, that the request is refused while the grant is high, and that exactly one new row-strobe fall follows. A long same-row burst under a short row-age limit makes the age close fall between hits. That case is judged by the maximum measured row-low time and by the count of row reopenings. The DRAM model in the bench drives junk while a column strobe is low and valid data only once both are high, so a sample taken too early shows up as a data mismatch.

// File: rtl/edo_ctrl_pkg.sv
`timescale 1ns/1ps
package edo_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // row closed and precharged
    ST_RCD,    // row strobe low, waiting before the first column
    ST_CSET,   // column address and write strobe set up
    ST_CAS,    // column strobe low
    ST_CPRE,   // column precharge, read sampling point
    ST_OPEN,   // row open, column strobes high
    ST_PRE,    // row precharge
    ST_REF     // DRAM handed to refresh
  } edo_state_e;

endpackage

// File: rtl/edo_cycle_timer.sv
`timescale 1ns/1ps
module edo_cycle_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/edo_row_tracker.sv
`timescale 1ns/1ps
module edo_row_tracker #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_en,
  input  logic             close_en,
  input  logic [ROW_W-1:0] row_in,
  output logic             hit
);

  logic [ROW_W-1:0] open_row;
  logic             row_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_row  <= '0;
      row_valid <= 1'b0;
    end else if (close_en) begin
      row_valid <= 1'b0;
    end else if (open_en) begin
      open_row  <= row_in;
      row_valid <= 1'b1;
    end
  end

  assign hit = row_valid && (open_row == row_in);

endmodule

// File: rtl/edo_ras_age.sv
`timescale 1ns/1ps
module edo_ras_age #(
  parameter int RAS_MAX = 20000,
  parameter int T_RAC   = 12,
  parameter int GUARD   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic row_low,
  output logic expired,
  output logic rac_met
);

  localparam int AGE_W = $clog2(RAS_MAX + 1);
  localparam logic [AGE_W-1:0] LIMIT_V = AGE_W'(RAS_MAX - GUARD);
  localparam logic [AGE_W-1:0] RAC_V   = AGE_W'(T_RAC);
  localparam logic [AGE_W-1:0] SAT_V   = AGE_W'(RAS_MAX);

  logic [AGE_W-1:0] age;

  always_ff @(posedge clk) begin
    if (rst || !row_low) age <= '0;
    else if (age != SAT_V) age <= age + 1'b1;
  end

  assign expired = (age >= LIMIT_V);
  assign rac_met = (age >= RAC_V);

endmodule

// File: rtl/edo_page_ctrl.sv
`timescale 1ns/1ps
module edo_page_ctrl #(
  parameter int MUX_W     = 10,
  parameter int DQ_W      = 16,
  parameter int T_RP      = 8,
  parameter int T_RCD     = 3,
  parameter int T_CAS     = 3,
  parameter int T_CP      = 2,
  parameter int T_RAC     = 12,
  parameter int T_RAS_MAX = 20000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [2*MUX_W-1:0]   req_addr,
  input  logic [DQ_W-1:0]      req_wdata,
  input  logic [1:0]           req_be,
  output logic                 rd_valid,
  output logic [DQ_W-1:0]      rd_data,
  input  logic                 ref_req,
  output logic                 ref_gnt,
  output logic                 dram_ras_n,
  output logic                 dram_casl_n,
  output logic                 dram_cash_n,
  output logic                 dram_we_n,
  output logic                 dram_oe_n,
  output logic [MUX_W-1:0]     dram_addr,
  output logic [DQ_W-1:0]      dram_dq_out,
  output logic                 dram_dq_oe,
  input  logic [DQ_W-1:0]      dram_dq_in
);
  import edo_ctrl_pkg::*;

  localparam int LANES  = 2;
  localparam int LANE_W = DQ_W / LANES;
  localparam int TMR_W  = $clog2(T_RP + T_RCD + T_CAS + T_CP + 1);
  // cycles an accepted hit can still keep the row low before OPEN is seen again
  localparam int GUARD  = T_CAS + T_CP + 3;

  edo_state_e st;

  logic [MUX_W-1:0]  req_row, req_col, col_q;
  logic              cur_wr;
  logic [LANES-1:0]  cur_be;
  logic              row_hit, age_expired, rac_met, tmr_done;
  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              accept, close_now;
  logic [DQ_W-1:0]   rd_masked;

  assign req_row = req_addr[2*MUX_W-1:MUX_W];
  assign req_col = req_addr[MUX_W-1:0];

  // host handshake: idle row or a hit on an open, young row
  always_comb begin
    req_ready = 1'b0;
    if (st == ST_IDLE)      req_ready = !ref_req;
    else if (st == ST_OPEN) req_ready = row_hit && !ref_req && !age_expired;
  end

  assign accept    = req_valid && req_ready;
  assign close_now = (st == ST_OPEN) &&
                     (ref_req || age_expired || (req_valid && !row_hit));

  // timer loads (value T-1 gives T cycles before done is seen)
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st)
      ST_IDLE: if (accept)   begin tmr_load = 1'b1; tmr_val = TMR_W'(T_RCD - 1); end
      ST_CSET:               begin tmr_load = 1'b1; tmr_val = TMR_W'(T_CAS - 1); end
      ST_CAS:  if (tmr_done) begin tmr_load = 1'b1; tmr_val = TMR_W'(T_CP - 1);  end
      ST_OPEN: if (close_now) begin tmr_load = 1'b1; tmr_val = TMR_W'(T_RP - 1); end
      default: ;
    endcase
  end

  edo_cycle_timer #(.CNT_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  edo_row_tracker #(.ROW_W(MUX_W)) u_rows (
    .clk      (clk),
    .rst      (rst),
    .open_en  ((st == ST_IDLE) && accept),
    .close_en (close_now),
    .row_in   (req_row),
    .hit      (row_hit)
  );

  edo_ras_age #(.RAS_MAX(T_RAS_MAX), .T_RAC(T_RAC), .GUARD(GUARD)) u_age (
    .clk     (clk),
    .rst     (rst),
    .row_low (!dram_ras_n),
    .expired (age_expired),
    .rac_met (rac_met)
  );

  // per-lane read masking: a lane whose strobe was not used reads zero
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rd_masked[l*LANE_W +: LANE_W] =
      cur_be[l] ? dram_dq_in[l*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      dram_ras_n  <= 1'b1;
      dram_casl_n <= 1'b1;
      dram_cash_n <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_addr   <= '0;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
      ref_gnt     <= 1'b0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      cur_wr      <= 1'b0;
      cur_be      <= '0;
      col_q       <= '0;
    end else begin
      rd_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (ref_req) begin
            ref_gnt <= 1'b1;
            st      <= ST_REF;
          end else if (req_valid) begin
            cur_wr      <= req_write;
            cur_be      <= req_be;
            col_q       <= req_col;
            dram_dq_out <= req_wdata;
            dram_addr   <= req_row;
            dram_ras_n  <= 1'b0;
            st          <= ST_RCD;
          end
        end
        ST_RCD: begin
          if (tmr_done) begin
            dram_addr  <= col_q;
            dram_we_n  <= !cur_wr;
            dram_oe_n  <= cur_wr;
            dram_dq_oe <= cur_wr;
            st         <= ST_CSET;
          end
        end
        ST_CSET: begin
          dram_casl_n <= !cur_be[0];
          dram_cash_n <= !cur_be[1];
          st          <= ST_CAS;
        end
        ST_CAS: begin
          if (tmr_done) begin
            dram_casl_n <= 1'b1;
            dram_cash_n <= 1'b1;
            dram_we_n   <= 1'b1;
            dram_dq_oe  <= 1'b0;
            st          <= ST_CPRE;
          end
        end
        ST_CPRE: begin
          if (tmr_done && rac_met) begin
            if (!cur_wr) begin
              rd_valid <= 1'b1;
              rd_data  <= rd_masked;
            end
            dram_oe_n <= 1'b1;
            st        <= ST_OPEN;
          end
        end
        ST_OPEN: begin
          if (close_now) begin
            dram_ras_n <= 1'b1;
            st         <= ST_PRE;
          end else if (accept) begin
            cur_wr      <= req_write;
            cur_be      <= req_be;
            dram_dq_out <= req_wdata;
            dram_addr   <= req_col;
            dram_we_n   <= !req_write;
            dram_oe_n   <= req_write;
            dram_dq_oe  <= req_write;
            st          <= ST_CSET;
          end
        end
        ST_PRE: begin
          if (tmr_done) st <= ST_IDLE;
        end
        ST_REF: begin
          if (!ref_req) begin
            ref_gnt <= 1'b0;
            st      <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/edo_page_ctrl_chk.sv
`timescale 1ns/1ps
module edo_page_ctrl_chk #(
  parameter int T_RP      = 8,
  parameter int T_RAS_MAX = 20000
) (
  input logic clk,
  input logic rst,
  input logic dram_ras_n,
  input logic dram_casl_n,
  input logic dram_cash_n,
  input logic dram_we_n,
  input logic dram_oe_n,
  input logic ref_gnt,
  input logic req_ready,
  input logic rd_valid
);

  logic [31:0] lo_cnt, hi_cnt;
  logic        cas_any;

  assign cas_any = !dram_casl_n || !dram_cash_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt <= '0;
      hi_cnt <= 32'(T_RP);
    end else begin
      lo_cnt <= dram_ras_n ? '0 : lo_cnt + 1;
      hi_cnt <= dram_ras_n ? hi_cnt + 1 : '0;
    end
  end

  // R2: column strobes only inside an open row
  p_cas_in_row_r2: assert property (@(posedge clk) disable iff (rst)
    cas_any |-> !dram_ras_n);

  // R6: write strobe settled before the column strobe falls
  p_early_we_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(cas_any) && !dram_we_n) |-> $past(!dram_we_n));

  // R6: output enable off whenever writing
  p_write_oe_r6: assert property (@(posedge clk) disable iff (rst)
    !dram_we_n |-> dram_oe_n);

  // R8: read data returned from an open row
  p_rd_in_row_r8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !dram_ras_n);

  // R9: row-low window bounded
  p_ras_window_r9: assert property (@(posedge clk) disable iff (rst)
    !dram_ras_n |-> (lo_cnt < 32'(T_RAS_MAX)));

  // R10: grant only with all strobes idle, and no host accept meanwhile
  p_gnt_closed_r10: assert property (@(posedge clk) disable iff (rst)
    ref_gnt |-> (dram_ras_n && !cas_any && !req_ready));

  // R11: row precharge before every reopen
  p_ras_precharge_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> (hi_cnt >= 32'(T_RP)));

endmodule

bind edo_page_ctrl edo_page_ctrl_chk #(.T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .dram_ras_n  (dram_ras_n),
  .dram_casl_n (dram_casl_n),
  .dram_cash_n (dram_cash_n),
  .dram_we_n   (dram_we_n),
  .dram_oe_n   (dram_oe_n),
  .ref_gnt     (ref_gnt),
  .req_ready   (req_ready),
  .rd_valid    (rd_valid)
);

// File: tb/edo_page_ctrl_tb.sv
`timescale 1ns/1ps
module edo_page_ctrl_tb;
  localparam int MW = 10, DW = 16;
  localparam int TRP = 8, TRCD = 3, TCAS = 3, TCP = 2, TRAC = 12, RASMAX = 60;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
  logic [2*MW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rd_valid, ref_gnt;
  logic [DW-1:0] rd_data, dram_dq_out, dram_dq_in;
  logic dram_ras_n, dram_casl_n, dram_cash_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [MW-1:0] dram_addr;

  always #2.5 clk = ~clk;

  edo_page_ctrl #(.MUX_W(MW), .DQ_W(DW), .T_RP(TRP), .T_RCD(TRCD), .T_CAS(TCAS),
                  .T_CP(TCP), .T_RAC(TRAC), .T_RAS_MAX(RASMAX)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .dram_ras_n(dram_ras_n), .dram_casl_n(dram_casl_n), .dram_cash_n(dram_cash_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_addr(dram_addr),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

  int checks = 0, fails = 0, ras_falls = 0;
  bit finished = 1'b0;
  logic [15:0] dmem [int];
  logic [15:0] shadow [int];
  logic [15:0] expq [$];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  // behavioural DRAM: junk while a column strobe is low, data once both are high
  logic [MW-1:0] m_row;
  logic [15:0]   m_word;
  bit            m_have;
  assign dram_dq_in = (!m_have || dram_ras_n || !dram_casl_n || !dram_cash_n) ? 16'hBAD0 : m_word;

  bit p_ras, p_caslo, p_we, p_gnt;
  int ras_lo, ras_hi, cas_lo, cas_hi;

  always @(negedge clk) begin
    logic caslo;
    logic [15:0] w, e;
    int k;
    if (rst) begin
      p_ras = 1; p_caslo = 0; p_we = 1; p_gnt = 0;
      ras_lo = 0; ras_hi = TRP; cas_lo = 0; cas_hi = TCP; m_have = 0;
    end else begin
      caslo = !dram_casl_n || !dram_cash_n;
      if (p_ras && !dram_ras_n) begin
        chk(ras_hi >= TRP, "R11", ras_hi, TRP);
        ras_falls++;
        m_row = dram_addr;
      end
      if (!p_ras && dram_ras_n) begin
        chk(ras_lo <= RASMAX, "R9", ras_lo, RASMAX);
        m_have = 0;
      end
      if (!p_caslo && caslo) begin
        chk(!dram_ras_n, "R2", dram_ras_n, 0);
        chk(ras_lo >= TRCD, "R2", ras_lo, TRCD);
        chk(cas_hi >= TCP, "R7", cas_hi, TCP);
        k = int'({m_row, dram_addr});
        w = dmem.exists(k) ? dmem[k] : 16'h0000;
        if (!dram_we_n) begin
          chk(!p_we, "R6", p_we, 0);
          chk(dram_oe_n && dram_dq_oe, "R6", {dram_oe_n, dram_dq_oe}, 2'b11);
          if (!dram_casl_n) w[7:0]  = dram_dq_out[7:0];
          if (!dram_cash_n) w[15:8] = dram_dq_out[15:8];
          dmem[k] = w;
        end else begin
          chk(!dram_dq_oe, "R6", dram_dq_oe, 0);
          m_word = {(!dram_cash_n ? w[15:8] : 8'hA5), (!dram_casl_n ? w[7:0] : 8'hA5)};
          m_have = 1;
        end
      end
      if (p_caslo && !caslo) chk(cas_lo >= TCAS, "R7", cas_lo, TCAS);
      if (ref_gnt && !p_gnt) chk(dram_ras_n && !caslo, "R10", {dram_ras_n, caslo}, 2'b10);
      if (rd_valid) begin
        if (expq.size() == 0) chk(0, "R8", rd_data, 0);
        else begin
          e = expq.pop_front();
          chk(rd_data == e, "R8", rd_data, e);
        end
        chk(ras_lo >= TRAC, "R8", ras_lo, TRAC);
      end
      ras_lo = dram_ras_n ? 0 : ras_lo + 1;
      ras_hi = dram_ras_n ? ras_hi + 1 : 0;
      cas_lo = caslo ? cas_lo + 1 : 0;
      cas_hi = caslo ? 0 : cas_hi + 1;
      p_ras = dram_ras_n; p_caslo = caslo; p_we = dram_we_n; p_gnt = ref_gnt;
    end
  end

  task automatic issue(input bit wr, input int row, input int col, input logic [15:0] d,
                       input logic [1:0] be);
    int k;
    logic [15:0] w;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = {MW'(row), MW'(col)};
    req_wdata = d; req_be = be;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 0;
    k = int'({MW'(row), MW'(col)});
    w = shadow.exists(k) ? shadow[k] : 16'h0000;
    if (wr) begin
      if (be[0]) w[7:0]  = d[7:0];
      if (be[1]) w[15:8] = d[15:8];
      shadow[k] = w;
    end else expq.push_back(w & lane_mask(be));
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int rf;
    repeat (3) @(negedge clk);
    // R1: idle strobes under reset
    chk(dram_ras_n && dram_casl_n && dram_cash_n && dram_we_n && dram_oe_n &&
        !dram_dq_oe && !ref_gnt && !rd_valid, "R1", 0, 1);
    rst = 0;
    @(negedge clk);
    chk(dram_ras_n && dram_casl_n && dram_cash_n && !ref_gnt, "R1", 0, 1);

    // R3 / R2: page hits in one row
    rf = ras_falls;
    issue(1, 5, 1, 16'h1111, 2'b11);
    issue(1, 5, 2, 16'h2222, 2'b11);
    issue(0, 5, 1, 16'h0, 2'b11);
    issue(0, 5, 2, 16'h0, 2'b11);
    drain();
    chk(ras_falls - rf == 1, "R3", ras_falls - rf, 1);
    chk(m_row == 5, "R2", m_row, 5);

    // R4: alternating rows
    rf = ras_falls;
    issue(1, 6, 3, 16'h6363, 2'b11);
    issue(1, 7, 3, 16'h7373, 2'b11);
    issue(0, 6, 3, 16'h0, 2'b11);
    issue(0, 7, 3, 16'h0, 2'b11);
    drain();
    chk(ras_falls - rf == 4, "R4", ras_falls - rf, 4);

    // R5 / R8: byte lanes
    issue(1, 9, 4, 16'h1234, 2'b11);
    issue(1, 9, 4, 16'hFFAB, 2'b01);
    issue(1, 9, 4, 16'hCDFF, 2'b10);
    issue(0, 9, 4, 16'h0, 2'b11);
    issue(0, 9, 4, 16'h0, 2'b01);
    issue(0, 9, 4, 16'h0, 2'b10);
    drain();

    // R10: refresh arriving together with a hit on the open row
    rf = ras_falls;
    fork
      issue(0, 9, 4, 16'h0, 2'b11);
      begin
        @(negedge clk);
        ref_req = 1;
        while (!ref_gnt) @(negedge clk);
        repeat (10) begin
          @(negedge clk); #1;
          chk(!req_ready && dram_ras_n, "R10", {req_ready, dram_ras_n}, 2'b01);
        end
        @(negedge clk);
        ref_req = 0;
      end
    join
    drain();
    chk(ras_falls - rf == 1, "R10", ras_falls - rf, 1);
    chk(!ref_gnt, "R10", ref_gnt, 0);

    // R9: long same-row burst must be split by the age limit
    rf = ras_falls;
    for (int i = 0; i < 14; i++) begin
      if (i % 2 == 0) issue(1, 3, i, 16'(16'h3000 + i), 2'b11);
      else            issue(0, 3, i - 1, 16'h0, 2'b11);
    end
    drain();
    chk(ras_falls - rf >= 2, "R9", ras_falls - rf, 2);

    // R5: final memory image against the shadow
    foreach (shadow[k]) chk(dmem.exists(k) && dmem[k] == shadow[k], "R5",
                            dmem.exists(k) ? dmem[k] : 16'hXXXX, shadow[k]);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule